// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the word-addressed register bank that sits between a simple 32-bit bus and the datapath of a serial port. Software uses it to configure framing and flow options, read line and FIFO status, move bytes through a shared receive/transmit data window, and service interrupts. The transmit and receive engines, the FIFOs and the baud generator live elsewhere. They reach this bank through plain level and strobe ports.

Interrupts come from ten level conditions raised by the datapath. Each condition is latched into a sticky cause bit. Software enables individual causes through a mask and acknowledges them by writing the cause word back. Line commands (the ready-to-send output and the two FIFO flushes) are changed through a pair of addresses. One address only sets bits and the other only clears them, so no read-modify-write is needed.

Top module: `uart_csr_bank`

## Requirements
- R1: After a clock edge with `rst_n` low, the control, trigger, mask, cause and command state are all zero, `irq` is 0, `rts` is 0 and both flush strobes are 0.
- R2: The control word at offset 0x00 keeps bits 0 (enable), 1 (8 data bits, else 7), 2 (two stop bits), 3 (parity enable), 5:4 (parity kind: 0 odd, 1 even, 2 space, 3 mark), 23 (hardware flow control) and 24 (loopback). It drives them onto the matching config outputs from the cycle after the write. All other bits read 0.
- R3: The trigger word at offset 0x14 keeps the receive level in bits 4:0, the transmit level in bits 11:8 and the flow-control level in bits 20:16, each on its own output. All other bits read 0.
- R4: A source at index i of `evt_lvl` that is high at a clock edge sets latched cause i, which reads at bit 16+i of offset 0x10. The bit stays set until it is acknowledged.
- R5: A write to offset 0x10 with bit i or bit 16+i set clears latched cause i at that edge, unless source i is high at the same edge. In that case the cause stays set.
- R6: The mask at offset 0x0C holds bits 9:0. Bits 9:0 of offset 0x10 read the latched causes ANDed with the mask.
- R7: `irq` is high exactly when some latched cause has its mask bit set.
- R8: Writing 1 to bit 5 at offset 0x18 sets `rts`, and writing 1 to bit 5 at offset 0x1C clears it. Both offsets read `rts` at bit 5 and 0 in every other bit.
- R9: Writing 1 to bit 6 (receive) or bit 7 (transmit) at offset 0x18 produces a one-cycle high on `rx_flush` or `tx_flush` in the cycle after the write. These bits read back 0, and writing them at offset 0x1C produces no strobe.
- R10: Offset 0x04 reads the receive fill count in bits 6:0 and the transmit free count in bits 12:8. It also reads tx busy 14, rx busy 15, rx overrun 16, tx overrun 17, parity error 18, framing error 19, break 20 and CTS 25, with other bits 0. Writes to it change nothing.
- R11: A write to offset 0x08 raises `tx_push` in the same cycle, with `tx_byte` equal to write-data bits 7:0.
- R12: A read of offset 0x08 returns `rx_byte` and raises `rx_pop` in the same cycle when `rx_level` is nonzero. When `rx_level` is zero it returns 0 and `rx_pop` stays low.
- R13: An access whose address bits 1:0 are not zero selects no register. It reads 0 and its write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt_lvl | input | 10 | Interrupt source levels |
| rx_level | input | 7 | Receive FIFO fill count |
| tx_space | input | 5 | Transmit FIFO free slots |
| tx_busy | input | 1 | Transmitter shifting |
| rx_busy | input | 1 | Receiver shifting |
| rx_ovr | input | 1 | Receive overrun flag |
| tx_ovr | input | 1 | Transmit overrun flag |
| par_err | input | 1 | Parity error flag |
| frm_err | input | 1 | Framing error flag |
| brk_det | input | 1 | Break detected |
| cts_in | input | 1 | Clear-to-send level |
| rx_byte | input | 8 | Head of receive FIFO |
| rx_pop | output | 1 | Pop receive FIFO |
| tx_byte | output | 8 | Byte to push |
| tx_push | output | 1 | Push transmit FIFO |
| rx_flush | output | 1 | Receive FIFO flush strobe |
| tx_flush | output | 1 | Transmit FIFO flush strobe |
| rts | output | 1 | Ready-to-send output |
| cfg_en | output | 1 | Port enable |
| cfg_data8 | output | 1 | 8 data bits |
| cfg_stop2 | output | 1 | Two stop bits |
| cfg_par_en | output | 1 | Parity enable |
| cfg_par_kind | output | 2 | Parity kind |
| cfg_flow_en | output | 1 | Hardware flow control |
| cfg_loop | output | 1 | Loopback |
| trig_rx | output | 5 | Receive trigger level |
| trig_tx | output | 4 | Transmit trigger level |
| trig_flow | output | 5 | Flow-control level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every source level in `evt_lvl` is already synchronous to `clk` and free of X once reset is released. They also assume that bus fields are stable for the whole cycle in which `bus_sel` is high. The stimulus changes every input only on the falling clock edge, so sources and bus fields are settled at each rising edge. The sequences raise sources while an acknowledge to the same index is under way, issue flush commands back to back, and use misaligned addresses, all without leaving those assumptions.

// File: rtl/uart_csr_pkg.sv
// Package: shared register indices, write masks and command bit positions
// for the serial port register bank. Assumes a 32-bit data bus.
package uart_csr_pkg;
    localparam int NREG = 8;

    typedef enum logic [2:0] {
        RG_CTRL  = 3'd0,
        RG_STAT  = 3'd1,
        RG_DATA  = 3'd2,
        RG_MASK  = 3'd3,
        RG_CAUSE = 3'd4,
        RG_TRIG  = 3'd5,
        RG_CSET  = 3'd6,
        RG_CCLR  = 3'd7
    } reg_idx_e;

    localparam logic [31:0] CTRL_KEEP = 32'h0180_003F;
    localparam logic [31:0] TRIG_KEEP = 32'h001F_0F1F;
    localparam int RAW_LSB = 16;
    localparam int CMD_RTS = 5;
    localparam int CMD_RXF = 6;
    localparam int CMD_TXF = 7;
endpackage

// File: rtl/uart_csr_decode.sv
// Module: address decoder. Turns one bus access into one-hot read and
// write hit vectors. Assumes word-aligned registers; an access with
// nonzero low address bits selects nothing.
module uart_csr_decode #(
    parameter int AW   = 5,
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] wr_hit,
    output logic [NREG-1:0] rd_hit
);
    localparam int IW = AW - 2;

    logic aligned;
    // Word alignment qualifier for every hit.
    assign aligned = (addr[1:0] == 2'b00);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_hit
            // One compare per register slot.
            assign wr_hit[g] = sel & wr  & aligned & (addr[AW-1:2] == IW'(g));
            assign rd_hit[g] = sel & ~wr & aligned & (addr[AW-1:2] == IW'(g));
        end
    endgenerate

    // R13: at most one register is touched per cycle, none when misaligned.
    a_r13_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_hit, rd_hit}) && (!aligned -> ({wr_hit, rd_hit} == '0)));
endmodule

// File: rtl/uart_csr_cause.sv
// Module: sticky interrupt causes. Each source level sets its cause bit,
// a write-one acknowledge clears it unless the source is still high.
// Assumes source levels are synchronous to clk.
module uart_csr_cause #(
    parameter int NSRC = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic [NSRC-1:0] ack,
    input  logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] raw_q,
    output logic [NSRC-1:0] masked,
    output logic            irq
);
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            // Latch one cause; a live source wins over acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n) raw_q[g] <= 1'b0;
                else        raw_q[g] <= (raw_q[g] & ~ack[g]) | src_lvl[g];
            end

            // R4: an unacknowledged cause never drops.
            a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (raw_q[g] && !ack[g]) |=> raw_q[g]);
            // R4: a cause only appears when its source was high.
            a_r4_origin: assert property (@(posedge clk) disable iff (!rst_n)
                (!raw_q[g] && !src_lvl[g]) |=> !raw_q[g]);
            // R5: acknowledge with a quiet source clears the cause.
            a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[g] && !src_lvl[g]) |=> !raw_q[g]);
        end
    endgenerate

    // Masked view and the request line.
    assign masked = raw_q & mask;
    assign irq    = |masked;

    // R7: a request always has a latched cause behind it.
    a_r7_irq_backed: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_q != '0));
endmodule

// File: rtl/uart_csr_cmd.sv
// Module: command state behind the set/clear address pair. Holds the
// ready-to-send bit and issues one-cycle FIFO flush strobes. Assumes
// set and clear writes never occur in the same cycle (distinct addresses).
module uart_csr_cmd (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [2:0]  wbits,     // {tx flush, rx flush, rts}
    output logic        rts,
    output logic        rx_flush,
    output logic        tx_flush,
    output logic [31:0] rd_val
);
    import uart_csr_pkg::*;

    // Ready-to-send: set by the set address, cleared by the clear address.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rts <= 1'b0;
        else if (set_we && wbits[0]) rts <= 1'b1;
        else if (clr_we && wbits[0]) rts <= 1'b0;
    end

    // Flush strobes: registered, high for the cycle after a set write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= set_we & wbits[1];
            tx_flush <= set_we & wbits[2];
        end
    end

    // Readback: only the held bit is visible.
    always_comb begin
        rd_val          = '0;
        rd_val[CMD_RTS] = rts;
    end

    // R8: without a command write the ready-to-send bit holds.
    a_r8_rts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(rts));
    // R9: each strobe traces back to a set write one cycle earlier.
    a_r9_rx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flush) |-> $past(set_we && wbits[1]));
    a_r9_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flush) |-> $past(set_we && wbits[2]));
endmodule

// File: rtl/uart_csr_bank.sv
// Module: serial port register bank (top). Holds control, trigger and
// mask words, assembles status, routes the data window to the FIFO
// strobes and combines the cause and command sub-blocks. Assumes a
// single-cycle bus with combinational read data.
module uart_csr_bank #(
    parameter int AW   = 5,
    parameter int NSRC = 10,
    parameter int RXCW = 7,
    parameter int TXCW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] evt_lvl,
    input  logic [RXCW-1:0] rx_level,
    input  logic [TXCW-1:0] tx_space,
    input  logic            tx_busy,
    input  logic            rx_busy,
    input  logic            rx_ovr,
    input  logic            tx_ovr,
    input  logic            par_err,
    input  logic            frm_err,
    input  logic            brk_det,
    input  logic            cts_in,
    input  logic [7:0]      rx_byte,
    output logic            rx_pop,
    output logic [7:0]      tx_byte,
    output logic            tx_push,
    output logic            rx_flush,
    output logic            tx_flush,
    output logic            rts,
    output logic            cfg_en,
    output logic            cfg_data8,
    output logic            cfg_stop2,
    output logic            cfg_par_en,
    output logic [1:0]      cfg_par_kind,
    output logic            cfg_flow_en,
    output logic            cfg_loop,
    output logic [4:0]      trig_rx,
    output logic [3:0]      trig_tx,
    output logic [4:0]      trig_flow,
    output logic            irq
);
    import uart_csr_pkg::*;

    logic [NREG-1:0] wr_hit, rd_hit;
    logic [31:0]     ctrl_q, trig_q;
    logic [NSRC-1:0] mask_q, ack, raw_q, masked;
    logic [31:0]     cmd_rd, status_w, cause_w;
    logic            rx_nonempty;

    uart_csr_decode #(.AW(AW), .NREG(NREG)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr),
        .addr(bus_addr), .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    // Configuration words: keep only defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            trig_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_hit[RG_CTRL]) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (wr_hit[RG_TRIG]) trig_q <= bus_wdata & TRIG_KEEP;
            if (wr_hit[RG_MASK]) mask_q <= bus_wdata[NSRC-1:0];
        end
    end

    // Acknowledge accepts either half of a cause readback.
    assign ack = wr_hit[RG_CAUSE]
               ? (bus_wdata[NSRC-1:0] | bus_wdata[RAW_LSB +: NSRC]) : '0;

    uart_csr_cause #(.NSRC(NSRC)) u_cause (
        .clk(clk), .rst_n(rst_n), .src_lvl(evt_lvl), .ack(ack),
        .mask(mask_q), .raw_q(raw_q), .masked(masked), .irq(irq)
    );

    uart_csr_cmd u_cmd (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_hit[RG_CSET]), .clr_we(wr_hit[RG_CCLR]),
        .wbits(bus_wdata[CMD_TXF:CMD_RTS]),
        .rts(rts), .rx_flush(rx_flush), .tx_flush(tx_flush), .rd_val(cmd_rd)
    );

    // Status word assembled from datapath levels.
    always_comb begin
        status_w                = '0;
        status_w[RXCW-1:0]      = rx_level;
        status_w[8 +: TXCW]     = tx_space;
        status_w[14]            = tx_busy;
        status_w[15]            = rx_busy;
        status_w[16]            = rx_ovr;
        status_w[17]            = tx_ovr;
        status_w[18]            = par_err;
        status_w[19]            = frm_err;
        status_w[20]            = brk_det;
        status_w[25]            = cts_in;
    end

    // Cause word: masked view low, latched view high.
    always_comb begin
        cause_w                     = '0;
        cause_w[NSRC-1:0]           = masked;
        cause_w[RAW_LSB +: NSRC]    = raw_q;
    end

    // Data window strobes, same cycle as the access.
    assign rx_nonempty = (rx_level != '0);
    assign rx_pop      = rd_hit[RG_DATA] & rx_nonempty;
    assign tx_push     = wr_hit[RG_DATA];
    assign tx_byte     = bus_wdata[7:0];

    // Read multiplexer over the one-hot read hits.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit[RG_CTRL])  bus_rdata = ctrl_q;
        if (rd_hit[RG_STAT])  bus_rdata = status_w;
        if (rd_hit[RG_DATA])  bus_rdata = rx_nonempty ? {24'd0, rx_byte} : '0;
        if (rd_hit[RG_MASK])  bus_rdata = {{(32-NSRC){1'b0}}, mask_q};
        if (rd_hit[RG_CAUSE]) bus_rdata = cause_w;
        if (rd_hit[RG_TRIG])  bus_rdata = trig_q;
        if (rd_hit[RG_CSET] || rd_hit[RG_CCLR]) bus_rdata = cmd_rd;
    end

    // Decoded configuration fields.
    assign cfg_en       = ctrl_q[0];
    assign cfg_data8    = ctrl_q[1];
    assign cfg_stop2    = ctrl_q[2];
    assign cfg_par_en   = ctrl_q[3];
    assign cfg_par_kind = ctrl_q[5:4];
    assign cfg_flow_en  = ctrl_q[23];
    assign cfg_loop     = ctrl_q[24];
    assign trig_rx      = trig_q[4:0];
    assign trig_tx      = trig_q[11:8];
    assign trig_flow    = trig_q[20:16];

    // R2: control changes only through its own write.
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit[RG_CTRL] |=> $stable(ctrl_q));
    // R12: an empty receive FIFO is never popped.
    a_r12_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> !rx_pop);
endmodule

// File: tb/sim_uart_csr_bank.sv
// Bench: behavioural reference model compared with the design every clock.
module sim_uart_csr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  evt_lvl = '0;
    logic [6:0]  rx_level = '0;
    logic [4:0]  tx_space = '0;
    logic        tx_busy = 0, rx_busy = 0, rx_ovr = 0, tx_ovr = 0;
    logic        par_err = 0, frm_err = 0, brk_det = 0, cts_in = 0;
    logic [7:0]  rx_byte = '0;
    logic        rx_pop, tx_push, rx_flush, tx_flush, rts, irq;
    logic [7:0]  tx_byte;
    logic        cfg_en, cfg_data8, cfg_stop2, cfg_par_en, cfg_flow_en, cfg_loop;
    logic [1:0]  cfg_par_kind;
    logic [4:0]  trig_rx, trig_flow;
    logic [3:0]  trig_tx;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Reference state.
    logic [31:0] m_ctrl, m_trig;
    logic [9:0]  m_mask, m_cause;
    logic        m_rts, m_rxf, m_txf;

    always #10 clk = ~clk;

    uart_csr_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_lvl(evt_lvl), .rx_level(rx_level), .tx_space(tx_space),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .rx_ovr(rx_ovr), .tx_ovr(tx_ovr),
        .par_err(par_err), .frm_err(frm_err), .brk_det(brk_det), .cts_in(cts_in),
        .rx_byte(rx_byte), .rx_pop(rx_pop), .tx_byte(tx_byte), .tx_push(tx_push),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .rts(rts),
        .cfg_en(cfg_en), .cfg_data8(cfg_data8), .cfg_stop2(cfg_stop2),
        .cfg_par_en(cfg_par_en), .cfg_par_kind(cfg_par_kind),
        .cfg_flow_en(cfg_flow_en), .cfg_loop(cfg_loop),
        .trig_rx(trig_rx), .trig_tx(trig_tx), .trig_flow(trig_flow), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        logic [31:0] v;
        v = '0;
        if (a[1:0] != 2'b00) return '0;               // R13
        case (a[4:2])
            3'd0: v = m_ctrl;
            3'd1: v = {6'd0, cts_in, 4'd0, brk_det, frm_err, par_err, tx_ovr,
                       rx_ovr, rx_busy, tx_busy, 1'b0, tx_space, 1'b0, rx_level};
            3'd2: v = (rx_level != 0) ? {24'd0, rx_byte} : '0;
            3'd3: v = {22'd0, m_mask};
            3'd4: v = {6'd0, m_cause, 6'd0, m_cause & m_mask};
            3'd5: v = m_trig;
            default: v = {26'd0, m_rts, 5'd0};
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a[1:0] != 2'b00) return "R13";
        case (a[4:2])
            3'd0: return "R2";
            3'd1: return "R10";
            3'd2: return "R12";
            3'd3: return "R6";
            3'd4: return "R4/R5/R6";
            3'd5: return "R3";
            default: return "R8";
        endcase
    endfunction

    // Reference update at the edge, then comparison once outputs settle.
    always @(posedge clk) begin
        logic w;
        logic [9:0] ack;
        w = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
        if (!rst_n) begin
            m_ctrl = '0; m_trig = '0; m_mask = '0; m_cause = '0;
            m_rts = 0; m_rxf = 0; m_txf = 0;
        end else begin
            ack = (w && bus_addr[4:2] == 3'd4) ? (bus_wdata[9:0] | bus_wdata[25:16]) : '0;
            m_cause = (m_cause & ~ack) | evt_lvl;
            if (w && bus_addr[4:2] == 3'd0) m_ctrl = bus_wdata & 32'h0180_003F;
            if (w && bus_addr[4:2] == 3'd5) m_trig = bus_wdata & 32'h001F_0F1F;
            if (w && bus_addr[4:2] == 3'd3) m_mask = bus_wdata[9:0];
            m_rxf = w && bus_addr[4:2] == 3'd6 && bus_wdata[6];
            m_txf = w && bus_addr[4:2] == 3'd6 && bus_wdata[7];
            if (w && bus_addr[4:2] == 3'd6 && bus_wdata[5]) m_rts = 1;
            if (w && bus_addr[4:2] == 3'd7 && bus_wdata[5]) m_rts = 0;
        end
        #2;
        if (!rst_n) chk("R1", "reset irq/rts", {30'd0, irq, rts}, 32'd0);
        chk("R7", "irq", {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
        chk("R8", "rts", {31'd0, rts}, {31'd0, m_rts});
        chk("R9", "flush strobes", {30'd0, tx_flush, rx_flush}, {30'd0, m_txf, m_rxf});
        chk("R2", "config fields",
            {24'd0, cfg_loop, cfg_flow_en, cfg_par_kind, cfg_par_en, cfg_stop2, cfg_data8, cfg_en},
            {24'd0, m_ctrl[24], m_ctrl[23], m_ctrl[5:4], m_ctrl[3:0]});
        chk("R3", "trigger fields", {18'd0, trig_flow, trig_tx, trig_rx},
            {18'd0, m_trig[20:16], m_trig[11:8], m_trig[4:0]});
        chk("R11", "tx push", {23'd0, tx_push, tx_byte},
            {23'd0, (bus_sel && bus_wr && bus_addr == 5'h08), bus_wdata[7:0]});
        chk("R12", "rx pop", {31'd0, rx_pop},
            {31'd0, bus_sel && !bus_wr && bus_addr == 5'h08 && rx_level != 0});
        if (bus_sel && !bus_wr)
            chk(tag_of(bus_addr), "read data", bus_rdata, exp_read(bus_addr));
    end

    task automatic acc(input logic w, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a);
        acc(1'b0, a, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset values of every register.
        for (int i = 0; i < 8; i++) rd(5'(i * 4));
        // R2: control bits, undefined bits dropped.
        acc(1, 5'h00, 32'hFFFF_FFFF); rd(5'h00);
        acc(1, 5'h00, 32'h0100_0026); rd(5'h00);
        // R3: trigger fields.
        acc(1, 5'h14, 32'hFFFF_FFFF); rd(5'h14);
        acc(1, 5'h14, 32'h0014_0A10); rd(5'h14);
        // R10: status is read-only and mirrors inputs.
        acc(1, 5'h04, 32'hFFFF_FFFF);
        rx_level = 7'd3; tx_space = 5'd16; cts_in = 1; par_err = 1; tx_busy = 1;
        rd(5'h04);
        // R13: misaligned access ignored.
        acc(1, 5'h01, 32'hFFFF_FFFF); rd(5'h01); rd(5'h00);
        // R4/R6/R7: pulse a source, then mask and acknowledge.
        acc(1, 5'h0C, 32'h0000_03FF); rd(5'h0C);
        @(negedge clk) evt_lvl = 10'b00_0000_0010;
        @(negedge clk) evt_lvl = '0;
        repeat (2) @(negedge clk);
        rd(5'h10);
        acc(1, 5'h10, 32'h0002_0000); rd(5'h10);       // R5 via high half
        // R5: acknowledge loses to a live source.
        @(negedge clk) evt_lvl = 10'b00_0000_1000;
        acc(1, 5'h10, 32'h0000_0008); rd(5'h10);
        evt_lvl = '0;
        acc(1, 5'h0C, 32'h0000_0000); rd(5'h10);       // R7 masked off
        acc(1, 5'h10, 32'h0000_0008); rd(5'h10);
        // R8/R9: command set/clear and flush strobes.
        acc(1, 5'h18, 32'h0000_0020); rd(5'h18); rd(5'h1C);
        acc(1, 5'h18, 32'h0000_0040);
        acc(1, 5'h18, 32'h0000_0080);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 5'h18; bus_wdata = 32'hE0;
        @(negedge clk); bus_wdata = 32'hC0;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        acc(1, 5'h1C, 32'h0000_00C0); rd(5'h18);
        acc(1, 5'h1C, 32'h0000_0020); rd(5'h1C);
        // R11/R12: data window.
        acc(1, 5'h08, 32'h0000_01A5);
        rx_byte = 8'h5C; rx_level = 7'd3; rd(5'h08);
        rx_level = 7'd0; rd(5'h08);
        // Mixed traffic.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            bus_sel = $urandom_range(0, 1) != 0;
            bus_wr = $urandom_range(0, 1) != 0;
            bus_addr = ($urandom_range(0, 9) == 0) ? 5'($urandom) : {3'($urandom), 2'b00};
            bus_wdata = $urandom;
            evt_lvl = 10'($urandom) & 10'($urandom) & 10'($urandom);
            rx_level = ($urandom_range(0, 2) == 0) ? 7'd0 : 7'($urandom);
            rx_byte = 8'($urandom); tx_space = 5'($urandom);
            {tx_busy, rx_busy, rx_ovr, tx_ovr, par_err, frm_err, brk_det, cts_in} = 8'($urandom);
        end
        @(negedge clk); bus_sel = 0;
        // R1: reset mid-run clears everything again.
        rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule